// File: doc/BRIEF.md
# Centisecond BCD Timer Counter

This block keeps elapsed time to one hundredth of a second as two decimal digits: a hundredths digit and a tenths digit, both counted in BCD. A 100 Hz tick enable, one clock wide, advances the count while the run bit is set. When both digits roll over from 99 to 00, the block raises a single-cycle carry output that can be used as a once-per-second event.

Software reaches the block through three 4-bit registers. Two of them expose the digits and one holds the run bit. A read of the tenths register also captures the hundredths digit into a holding latch. The following read of the hundredths register returns that captured value, so the pair read back as tenths first and then hundredths always belongs to one instant. A write to either digit register clears both digits together, whatever data is written.

Top module: `csec_timer`

## Requirements
- R1: After a synchronous reset, the run bit is 0, both digits and the holding latch are 0, rdata_o is 0 and carry_o is 0.
- R2: The control register sits at offset 2 with the run bit in bit 0. Writing 1 there starts counting and writing 0 stops it. A read of it returns the run bit in bit 0 and zeros in bits 3..1.
- R3: While running, every tick advances the hundredths digit by one in BCD (0..9). The tick that takes it from 9 to 0 also advances the tenths digit by one.
- R4: The tenths digit counts 0..9 in BCD. In the cycle after both digits wrap to 00, carry_o is high for exactly one cycle.
- R5: While the run bit is 0, ticks are ignored and both digits keep their values.
- R6: A read at offset 1 returns the tenths digit and copies the current hundredths digit into the holding latch.
- R7: A read at offset 0 returns the holding latch, not the live hundredths digit.
- R8: A write to offset 0 or offset 1 clears both digits to 0, whatever the write data.
- R9: When a clearing write and a tick fall in the same cycle, the clear wins and both digits become 0.
- R10: Read data appears on rdata_o in the cycle after rd_en_i and then holds. A read at offset 3 returns 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_i | input | 1 | 100 Hz count enable, one clock wide |
| rd_en_i | input | 1 | Register read strobe |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | ADDR_W | Register offset (0 hundredths, 1 tenths, 2 control) |
| wdata_i | input | DATA_W | Write data |
| rdata_o | output | DATA_W | Registered read data |
| carry_o | output | 1 | One-cycle pulse on the 99 to 00 rollover |

## Verification
The bench builds the block with its defaults: DATA_W of 4, RADIX of 10 and ADDR_W of 2. With these values a full 99 to 00 rollover takes only a hundred ticks, so the carry pulse and its single-cycle width can be checked directly. The 2-bit address also reaches the spare offset 3. A scoreboard queue checks every read, including the stale-latch case where the hundredths digit moves between the paired reads.

// File: rtl/csec_pkg.sv
package csec_pkg;
  // Register offsets; the read order tenths-then-hundredths depends on these
  localparam int OFF_HUND = 0;
  localparam int OFF_TENS = 1;
  localparam int OFF_CTRL = 2;
  localparam int NUM_DIGITS = 2;
  localparam int IDX_HUND = 0;
  localparam int IDX_TENS = 1;
endpackage

// File: rtl/csec_digit.sv
module csec_digit #(
  parameter int W     = 4,
  parameter int RADIX = 10
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr_i,
  input  logic         inc_i,
  output logic [W-1:0] q_o,
  output logic         last_o
);
  localparam logic [W-1:0] LAST = W'(RADIX - 1);

  logic [W-1:0] q;

  always_ff @(posedge clk) begin
    if (rst || clr_i)   q <= '0;
    else if (inc_i)     q <= (q == LAST) ? '0 : q + 1'b1;
  end

  assign q_o    = q;
  assign last_o = (q == LAST);

  p_digit_range_r3: assert property (@(posedge clk) disable iff (rst)
    q <= LAST);
  p_clear_zero_r8: assert property (@(posedge clk) disable iff (rst)
    clr_i |=> q == '0);
  p_hold_r5: assert property (@(posedge clk) disable iff (rst)
    (!clr_i && !inc_i) |=> $stable(q));
  p_step_r3: assert property (@(posedge clk) disable iff (rst)
    (inc_i && !clr_i && q != LAST) |=> q == $past(q) + 1'b1);
endmodule

// File: rtl/csec_regs.sv
module csec_regs
  import csec_pkg::*;
#(
  parameter int ADDR_W = 2,
  parameter int DATA_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_en_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [DATA_W-1:0] hund_i,
  input  logic [DATA_W-1:0] tens_i,
  output logic              run_o,
  output logic              clear_o,
  output logic [DATA_W-1:0] rdata_o
);
  localparam logic [ADDR_W-1:0] A_HUND = ADDR_W'(OFF_HUND);
  localparam logic [ADDR_W-1:0] A_TENS = ADDR_W'(OFF_TENS);
  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(OFF_CTRL);

  logic              run_q;
  logic [DATA_W-1:0] snap_q;
  logic [DATA_W-1:0] rdata_q;
  logic              unused_wdata;

  assign unused_wdata = ^wdata_i[DATA_W-1:1];

  // Clear on any write to either digit register; data ignored
  assign clear_o = wr_en_i && (addr_i == A_HUND || addr_i == A_TENS);

  always_ff @(posedge clk) begin
    if (rst)                              run_q <= 1'b0;
    else if (wr_en_i && addr_i == A_CTRL) run_q <= wdata_i[0];
  end

  always_ff @(posedge clk) begin
    if (rst)                              snap_q <= '0;
    else if (rd_en_i && addr_i == A_TENS) snap_q <= hund_i;
  end

  always_ff @(posedge clk) begin
    if (rst) rdata_q <= '0;
    else if (rd_en_i) begin
      case (addr_i)
        A_HUND:  rdata_q <= snap_q;
        A_TENS:  rdata_q <= tens_i;
        A_CTRL:  rdata_q <= {{(DATA_W-1){1'b0}}, run_q};
        default: rdata_q <= '0;
      endcase
    end
  end

  assign run_o   = run_q;
  assign rdata_o = rdata_q;

  p_ctrl_upper_r2: assert property (@(posedge clk) disable iff (rst)
    (rd_en_i && addr_i == A_CTRL) |=> rdata_o[DATA_W-1:1] == '0);
  p_rdata_hold_r10: assert property (@(posedge clk) disable iff (rst)
    !rd_en_i |=> $stable(rdata_o));
endmodule

// File: rtl/csec_timer.sv
module csec_timer
  import csec_pkg::*;
#(
  parameter int ADDR_W = 2,
  parameter int DATA_W = 4,
  parameter int RADIX  = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick_i,
  input  logic              rd_en_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              carry_o
);
  logic              run, clear;
  logic [DATA_W-1:0] dig [NUM_DIGITS];
  logic              last [NUM_DIGITS];
  logic              inc  [NUM_DIGITS+1];
  logic              carry_q;

  assign inc[0] = run && tick_i;

  for (genvar g = 0; g < NUM_DIGITS; g++) begin : g_digit
    csec_digit #(.W(DATA_W), .RADIX(RADIX)) digit_i (
      .clk   (clk),
      .rst   (rst),
      .clr_i (clear),
      .inc_i (inc[g]),
      .q_o   (dig[g]),
      .last_o(last[g])
    );
    assign inc[g+1] = inc[g] && last[g];
  end

  csec_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) regs_i (
    .clk    (clk),
    .rst    (rst),
    .rd_en_i(rd_en_i),
    .wr_en_i(wr_en_i),
    .addr_i (addr_i),
    .wdata_i(wdata_i),
    .hund_i (dig[IDX_HUND]),
    .tens_i (dig[IDX_TENS]),
    .run_o  (run),
    .clear_o(clear),
    .rdata_o(rdata_o)
  );

  always_ff @(posedge clk) begin
    if (rst) carry_q <= 1'b0;
    else     carry_q <= inc[NUM_DIGITS] && !clear;
  end

  assign carry_o = carry_q;

  p_carry_zero_r4: assert property (@(posedge clk) disable iff (rst)
    carry_o |-> (dig[IDX_HUND] == '0 && dig[IDX_TENS] == '0));
  p_carry_single_r4: assert property (@(posedge clk) disable iff (rst)
    carry_o |=> !carry_o);
  p_stopped_hold_r5: assert property (@(posedge clk) disable iff (rst)
    (!run && !clear) |=> ($stable(dig[IDX_HUND]) && $stable(dig[IDX_TENS])));
  p_clear_wins_r9: assert property (@(posedge clk) disable iff (rst)
    (clear && tick_i) |=> (dig[IDX_HUND] == '0 && dig[IDX_TENS] == '0));
endmodule

// File: tb/csec_timer_tb.sv
module csec_timer_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tick = 1'b0, rd_en = 1'b0, wr_en = 1'b0;
  logic [1:0] addr = '0;
  logic [3:0] wdata = '0;
  logic [3:0] rdata;
  logic       carry;

  always #2.5 clk = ~clk;

  csec_timer dut_i (
    .clk(clk), .rst(rst), .tick_i(tick), .rd_en_i(rd_en), .wr_en_i(wr_en),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .carry_o(carry)
  );

  int n_chk = 0, n_bad = 0, carry_seen = 0, carry_exp = 0, cyc = 0;
  int m_hund = 0, m_tens = 0, m_snap = 0;
  bit m_run = 0;
  logic [3:0] exp_q[$];
  string tag_q[$];
  logic rd_seen = 1'b0;

  task automatic check(bit ok, string tag, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  always @(posedge clk) rd_seen <= rd_en;

  // Monitor: pops expected read data one cycle after each strobe
  always @(negedge clk) begin
    if (carry) carry_seen++;
    if (rd_seen && exp_q.size() > 0) begin
      logic [3:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      check(rdata == e, t, rdata, e);
    end
  end

  task automatic model_tick();
    if (m_run) begin
      if (m_hund == 9) begin
        m_hund = 0;
        if (m_tens == 9) begin m_tens = 0; carry_exp++; end
        else m_tens++;
      end else m_hund++;
    end
  endtask

  task automatic ticks(int n);
    for (int i = 0; i < n; i++) begin
      tick = 1'b1; model_tick();
      @(negedge clk); tick = 1'b0;
      @(negedge clk);
    end
  endtask

  task automatic wr(int a, int d, bit with_tick = 0);
    addr = 2'(a); wdata = 4'(d); wr_en = 1'b1; tick = with_tick;
    if (a == 2) m_run = d[0];
    else if (a <= 1) begin m_hund = 0; m_tens = 0; end
    @(negedge clk); wr_en = 1'b0; tick = 1'b0;
  endtask

  task automatic rd(int a, string tag);
    logic [3:0] e;
    case (a)
      0: e = 4'(m_snap);
      1: begin e = 4'(m_tens); m_snap = m_hund; end
      2: e = {3'b0, m_run};
      default: e = '0;
    endcase
    exp_q.push_back(e); tag_q.push_back(tag);
    addr = 2'(a); rd_en = 1'b1;
    @(negedge clk); rd_en = 1'b0;
  endtask

  task automatic rd_pair(string tag);
    rd(1, {tag, " tenths"});
    rd(0, {tag, " hundredths"});
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(rdata == 4'd0, "R1 rdata after reset", rdata, 0);
    check(carry == 1'b0, "R1 carry after reset", carry, 0);
    rd(2, "R1 run bit after reset");
    rd(0, "R1 latch after reset");
    rd_pair("R1 digits after reset");

    ticks(5);
    rd_pair("R5 ticks ignored while stopped");

    wr(2, 4'hF);
    rd(2, "R2 run readback upper zero");
    ticks(7);
    rd_pair("R3 seven ticks");
    ticks(5);
    rd_pair("R3 hundredths wrap into tenths");

    rd(1, "R6 tenths read captures");
    ticks(3);
    rd(0, "R7 hundredths returns latch not live");
    rd_pair("R6 fresh pair");

    wr(2, 4'h0);
    rd(2, "R2 stop readback");
    ticks(4);
    rd_pair("R5 hold while stopped");
    wr(2, 4'h1);

    wr(0, 4'h9);
    rd_pair("R8 clear via hundredths write");
    ticks(13);
    wr(1, 4'hF);
    rd_pair("R8 clear via tenths write");

    ticks(6);
    wr(1, 4'h3, 1);
    rd_pair("R9 clear beats tick");
    ticks(1);
    rd_pair("R9 counting resumes after clear");

    wr(0, 0);
    ticks(99);
    @(negedge clk);
    check(carry_seen == 0, "R4 no carry before rollover", carry_seen, 0);
    rd_pair("R4 at 99");
    ticks(1);
    @(negedge clk);
    check(carry_seen == carry_exp, "R4 one carry pulse at rollover", carry_seen, carry_exp);
    rd_pair("R4 digits after rollover");

    rd(3, "R10 spare offset reads zero");
    rd(2, "R10 control read latency");
    repeat (4) @(negedge clk);
    check(exp_q.size() == 0, "R10 all reads returned", exp_q.size(), 0);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 20000);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule